// File: doc/BRIEF.md
# Periodic Tick Timer with Timestamp Counter

This unit gives a processor two time references behind a small word-addressed register window. The first is a 32-bit timestamp that advances on every clock and wraps silently, so software can take differences of two readings. The second is a down-counting tick timer. It reloads from a programmable divider and raises a sticky interrupt flag once per period. With a 100 MHz clock and a divider of 1,000,000 it ticks at 100 Hz. Within a period, the elapsed time is (divider − current count) clock periods.

Software writes the divider and issues a load operation, then a run operation. The tick flag reaches the `irq` pin only when its mask bit is set. A write of 1 to the acknowledge register clears the flag. The divider may be changed at any time, and the new value is picked up at the next reload. A rate-select bit chooses between counting on every clock and counting once per `PRESC` clocks.

Top module: `tick_timer_unit`

## Requirements
- R1: After a synchronous reset, the timestamp, divider, count, mask and tick flag all read 0, the tick timer is stopped and `irq` is 0.
- R2: The timestamp (word 0, read-only) increases by 1 on every clock after reset and wraps modulo 2^32. A write to word 0 has no effect on it.
- R3: Writing the control word (word 2) with op field bits[1:0] = 01 copies the divider (word 1) into the count (word 3) and stops the timer. While stopped, the count holds.
- R4: With op = 10 (run), the count decreases by 1 per count tick. On a tick where the count is 1 or 0, the tick flag (word 7, bit 0) is set and the count reloads from the divider, so the period is the divider value in ticks.
- R5: Control bit 2 selects the count rate: 0 counts on every clock, 1 counts once per `PRESC` clocks. Each control write restarts the rate prescaler, so the first slow tick comes `PRESC` clocks after that write.
- R6: The masked-status word (word 5, bit 0) reads tick flag AND mask (word 4, bit 0). `irq` presents that product, registered one clock later.
- R7: A write to the acknowledge word (word 6) with bit 0 = 1 clears the tick flag. A write there with bit 0 = 0 leaves the flag unchanged.
- R8: When an acknowledge write and an expiry occur on the same clock, the flag stays set.
- R9: A divider write while running does not change the period in progress. The new value is loaded at the next expiry.
- R10: op = 00 (stop) halts the count at its current value after that clock.
- R11: A read strobe returns on `bus_rdata` in the next clock the value held before that edge. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | Masked tick interrupt, registered |

## Verification
The hardest case to reach is an acknowledge that lands on exactly the clock of a new expiry. The design gives no hint of that clock at its ports except through counting. The stimulus loads a divider of 5 and starts the timer at full rate. It then issues back-to-back single-clock register accesses, so every later access occupies a known clock relative to the run command. This places the acknowledge write precisely on the second expiry and a control acknowledge between expiries. The same counted schedule also lands a divider change mid-period and a stop command on an expiry clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // word addresses of the register window
  localparam logic [2:0] A_TIME   = 3'd0;
  localparam logic [2:0] A_DIV    = 3'd1;
  localparam logic [2:0] A_CTRL   = 3'd2;
  localparam logic [2:0] A_COUNT  = 3'd3;
  localparam logic [2:0] A_MASK   = 3'd4;
  localparam logic [2:0] A_MSTAT  = 3'd5;
  localparam logic [2:0] A_ACK    = 3'd6;
  localparam logic [2:0] A_RAW    = 3'd7;

  typedef enum logic [1:0] {
    OP_STOP = 2'b00,
    OP_LOAD = 2'b01,
    OP_RUN  = 2'b10,
    OP_KEEP = 2'b11
  } tmr_op_e;
endpackage

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else     value <= value + W'(1);
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRESC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic slow_sel,
  output logic tick
);
  generate
    if (PRESC <= 1) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRESC);
      localparam logic [PW-1:0] LAST = PW'(PRESC - 1);
      logic [PW-1:0] pcnt;
      logic          wrap;
      assign wrap = (pcnt == LAST);
      always_ff @(posedge clk) begin
        if (rst || restart) pcnt <= '0;
        else if (wrap)      pcnt <= '0;
        else                pcnt <= pcnt + PW'(1);
      end
      assign tick = slow_sel ? wrap : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/tmr_tick_core.sv
module tmr_tick_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         run_set,
  input  logic         stop,
  input  logic         tick,
  input  logic         ack,
  input  logic [W-1:0] div,
  output logic [W-1:0] count,
  output logic         running,
  output logic         raw
);
  logic step;
  logic expire;

  assign step   = running && tick;
  assign expire = step && (count <= W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
      raw     <= 1'b0;
    end else begin
      if (load)        count <= div;
      else if (expire) count <= div;
      else if (step)   count <= count - W'(1);

      if (load || stop) running <= 1'b0;
      else if (run_set) running <= 1'b1;

      // a fresh expiry wins over a same-cycle acknowledge
      if (expire)   raw <= 1'b1;
      else if (ack) raw <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] time_val,
  input  logic [DW-1:0] count_val,
  input  logic          raw,
  output logic [DW-1:0] div_q,
  output logic          mask_q,
  output logic          slow_q,
  output logic          load_p,
  output logic          run_p,
  output logic          stop_p,
  output logic          ctrl_wr,
  output logic          ack_p,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int PADW = DW - 1;
  localparam int CPAD = DW - 3;

  tmr_op_e op_in;
  logic [1:0] op_q;

  assign op_in   = tmr_op_e'(bus_wdata[1:0]);
  assign ctrl_wr = bus_we && (bus_addr == AW'(A_CTRL));
  assign load_p  = ctrl_wr && (op_in == OP_LOAD);
  assign run_p   = ctrl_wr && (op_in == OP_RUN);
  assign stop_p  = ctrl_wr && (op_in == OP_STOP);
  assign ack_p   = bus_we && (bus_addr == AW'(A_ACK)) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      mask_q <= 1'b0;
      slow_q <= 1'b0;
      op_q   <= 2'b00;
    end else if (bus_we) begin
      if (bus_addr == AW'(A_DIV))  div_q  <= bus_wdata;
      if (bus_addr == AW'(A_MASK)) mask_q <= bus_wdata[0];
      if (ctrl_wr) begin
        slow_q <= bus_wdata[2];
        op_q   <= bus_wdata[1:0];
      end
    end
  end

  logic [DW-1:0] rmux;
  always_comb begin
    rmux = '0;
    case (bus_addr)
      AW'(A_TIME):  rmux = time_val;
      AW'(A_DIV):   rmux = div_q;
      AW'(A_CTRL):  rmux = {{CPAD{1'b0}}, slow_q, op_q};
      AW'(A_COUNT): rmux = count_val;
      AW'(A_MASK):  rmux = {{PADW{1'b0}}, mask_q};
      AW'(A_MSTAT): rmux = {{PADW{1'b0}}, raw & mask_q};
      AW'(A_RAW):   rmux = {{PADW{1'b0}}, raw};
      default:      rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (bus_re) rdata <= rmux;
      irq <= raw & mask_q;
    end
  end
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit #(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int PRESC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic [DW-1:0] time_w;
  logic [DW-1:0] count_w;
  logic [DW-1:0] div_w;
  logic          raw_w;
  logic          mask_w;
  logic          slow_w;
  logic          load_w;
  logic          run_w;
  logic          stop_w;
  logic          ctrl_w;
  logic          ack_w;
  logic          tick_w;
  logic          going_w;

  tmr_free_counter #(.W(DW)) u_time (
    .clk   (clk),
    .rst   (rst),
    .value (time_w)
  );

  tmr_prescaler #(.PRESC(PRESC)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .restart  (ctrl_w),
    .slow_sel (slow_w),
    .tick     (tick_w)
  );

  tmr_tick_core #(.W(DW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .load    (load_w),
    .run_set (run_w),
    .stop    (stop_w),
    .tick    (tick_w),
    .ack     (ack_w),
    .div     (div_w),
    .count   (count_w),
    .running (going_w),
    .raw     (raw_w)
  );

  tmr_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .time_val  (time_w),
    .count_val (count_w),
    .raw       (raw_w),
    .div_q     (div_w),
    .mask_q    (mask_w),
    .slow_q    (slow_w),
    .load_p    (load_w),
    .run_p     (run_w),
    .stop_p    (stop_w),
    .ctrl_wr   (ctrl_w),
    .ack_p     (ack_w),
    .rdata     (bus_rdata),
    .irq       (irq)
  );
endmodule

// File: rtl/tick_timer_unit_chk.sv
module tick_timer_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] time_v,
  input logic [DW-1:0] count_v,
  input logic [DW-1:0] div_v,
  input logic          raw_v,
  input logic          mask_v,
  input logic          going_v,
  input logic          tick_v,
  input logic          load_v,
  input logic          ack_v,
  input logic          irq_v
);
  logic expiry;
  assign expiry = going_v && tick_v && (count_v <= DW'(1)) && !load_v;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (count_v == '0) && !raw_v && !irq_v && !going_v && (time_v == '0)); // R1

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> time_v == $past(time_v) + DW'(1)); // R2

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!going_v && !load_v) |=> $stable(count_v)); // R10

  AST_EXPIRY_RELOAD: assert property (@(posedge clk) disable iff (rst)
    expiry |=> raw_v && (count_v == $past(div_v))); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (raw_v && !ack_v) |=> raw_v); // R7

  AST_ACK_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    (expiry && ack_v) |=> raw_v); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_v == $past(raw_v && mask_v)); // R6
endmodule

bind tick_timer_unit tick_timer_unit_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .time_v  (time_w),
  .count_v (count_w),
  .div_v   (div_w),
  .raw_v   (raw_w),
  .mask_v  (mask_w),
  .going_v (going_w),
  .tick_v  (tick_w),
  .load_v  (load_w),
  .ack_v   (ack_w),
  .irq_v   (irq)
);

// File: tb/tick_timer_unit_tb_top.sv
module tick_timer_unit_tb_top;
  localparam logic [2:0] W_TIME = 3'd0, W_DIV = 3'd1, W_CTRL = 3'd2, W_COUNT = 3'd3;
  localparam logic [2:0] W_MASK = 3'd4, W_MSTAT = 3'd5, W_ACK = 3'd6, W_RAW = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  int ecount   = 0;
  logic pend = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  tick_timer_unit #(.DW(32), .AW(3), .PRESC(4)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
    pend <= bus_re;
  end

  // monitor: compare each read result against the scoreboard queue
  always @(negedge clk) begin
    if (pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read got %0h expected %0h", t, bus_rdata, e);
      end
    end
  end

  // all tasks start and end at a falling edge; each uses exactly one rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back((a == W_TIME) ? 32'(ecount) : e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string t, input logic act, input logic e);
    n_checks++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // reset state, R1; read timing R11
    chk("R1 irq after reset", irq, 1'b0);
    rd(W_TIME, 0, "R11 timestamp first read");
    rd(W_COUNT, 0, "R1 count");
    rd(W_DIV, 0, "R1 divider");
    rd(W_MASK, 0, "R1 mask");
    rd(W_RAW, 0, "R1 flag");
    rd(W_MSTAT, 0, "R1 masked status");

    // load, then hold while stopped: R3
    wr(W_DIV, 32'd5);
    wr(W_CTRL, 32'h1);
    rd(W_COUNT, 5, "R3 load copies divider");
    idle(3);
    rd(W_COUNT, 5, "R3 count holds when stopped");

    // run at full rate: R4 (edge r is the run write)
    wr(W_CTRL, 32'h2);
    for (int j = 1; j <= 6; j++)
      rd(W_COUNT, (((j - 1) % 5) == 0) ? 32'd5 : 32'(5 - ((j - 1) % 5)), "R4 count sequence");
    rd(W_RAW, 1, "R4 flag after expiry");          // r+7
    rd(W_MSTAT, 0, "R6 masked with mask 0");       // r+8
    wr(W_MASK, 32'h1);                             // r+9
    wr(W_ACK, 32'h1);                              // r+10, same clock as expiry
    rd(W_RAW, 1, "R8 ack on expiry clock");        // r+11
    rd(W_MSTAT, 1, "R6 masked with mask 1");       // r+12
    chk("R6 irq pin asserted", irq, 1'b1);
    wr(W_ACK, 32'h1);                              // r+13
    rd(W_RAW, 0, "R7 ack clears flag");            // r+14
    chk("R6 irq pin released", irq, 1'b0);
    idle(1);                                       // r+15 expiry
    wr(W_ACK, 32'h0);                              // r+16
    rd(W_RAW, 1, "R7 ack with bit0 = 0 ignored");  // r+17
    wr(W_ACK, 32'h1);                              // r+18
    rd(W_RAW, 0, "R7 ack clears again");           // r+19
    idle(1);                                       // r+20 expiry, reload 5
    wr(W_DIV, 32'd3);                              // r+21
    rd(W_COUNT, 4, "R9 old period continues");
    rd(W_COUNT, 3, "R9 old period continues");
    rd(W_COUNT, 2, "R9 old period continues");
    rd(W_COUNT, 1, "R9 old period continues");
    rd(W_COUNT, 3, "R9 new divider at reload");
    rd(W_COUNT, 2, "R9 new divider counting");     // r+27
    wr(W_CTRL, 32'h0);                             // r+28 stop
    rd(W_COUNT, 3, "R10 stopped count");
    rd(W_COUNT, 3, "R10 stopped count holds");

    // slow rate: R5
    wr(W_DIV, 32'd8);
    wr(W_CTRL, 32'h5);
    wr(W_CTRL, 32'h6);
    for (int j = 1; j <= 9; j++)
      rd(W_COUNT, 32'(8 - (j - 1) / 4), "R5 prescaled count");

    // timestamp: R2
    wr(W_TIME, 32'h0);
    rd(W_TIME, 0, "R2 timestamp ignores write");
    rd(W_TIME, 0, "R2 timestamp advances");

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule